// File: doc/BRIEF.md
# Conversion Ready and Status Flag Controller

This block sits between the digital filter of a sigma-delta converter and its serial interface. It owns the output data register, drives the active-low ready line and produces the ready and steady bits of the status word. Filter results arrive as single-cycle strobes. Each one carries a fast-step marker and over-range and under-range indications. Before the register is written, the value is forced to saturation codes when the input is out of range or the reference is missing.

The ready line also reports calibration progress. It rises when a calibration begins and falls when the calibration finishes. When a calibration finishes, the block issues a write strobe to the calibration coefficient store, unless the reference is missing. The sync input, active low, stops all sequencing. While a read is in progress the data register is not changed. A result that arrives during a read is parked in a holding register and written when the read ends.

Top module: `conv_ready_ctrl`

## Requirements
- R1: After reset, rdy_n is 1, stat_stdy is 1, data_reg is all zeros and cal_we is 0.
- R2: A result strobe (result_valid=1, read_busy=0, sync_n=1, no calibration running) loads data_reg on that clock edge and drives rdy_n to 0 and stat_rdy to 1 from that edge onward.
- R3: A read-complete strobe (read_done=1) with no load in the same cycle returns rdy_n to 1.
- R4: An imminent-update strobe (upd_warn=1) returns rdy_n to 1 without changing data_reg. The next load drives rdy_n to 0 again.
- R5: While sync_n is 0, rdy_n and stat_stdy are held at 1, any running calibration is abandoned, and result strobes leave data_reg unchanged.
- R6: cal_start drives rdy_n and stat_stdy to 1. Result strobes are ignored until cal_done. cal_done drives rdy_n to 0 and pulses cal_we for one cycle, with cal_wdata equal to cal_data.
- R7: A load with result_fast=1 sets stat_stdy to 1. After such a load, the first load with result_fast=0 clears stat_stdy in the same edge at which rdy_n falls.
- R8: If no fast-step result has been loaded since the last reset, sync or calibration start, stat_stdy stays 1 across loads and is cleared by the first read-complete strobe. Later loads and reads do not set it again.
- R9: If ref_missing is 1 when a result arrives, data_reg is loaded with all ones. If ref_missing is 1 at cal_done, cal_we stays 0, but rdy_n still falls.
- R10: A result with result_over=1 is loaded as all ones. A result with result_under=1 (and result_over=0) is loaded as all zeros. Otherwise result_data is loaded unchanged.
- R11: A result that arrives while read_busy is 1 leaves data_reg and rdy_n unchanged. It is loaded at the first clock edge at which read_busy is 0.
- R12: When a load and read_done occur in the same cycle, the load wins and rdy_n goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_n | input | 1 | Filter sync hold, active low |
| result_valid | input | 1 | Conversion result strobe |
| result_data | input | DW | Raw filter result |
| result_fast | input | 1 | Result came from the fast-step path |
| result_over | input | 1 | Input above positive full scale |
| result_under | input | 1 | Input below negative full scale |
| ref_missing | input | 1 | Reference-absent flag |
| upd_warn | input | 1 | Strobe shortly before the next result |
| cal_start | input | 1 | Calibration begins |
| cal_done | input | 1 | Calibration finishes |
| cal_data | input | DW | Coefficient computed by the calibration |
| read_busy | input | 1 | Data register read in progress |
| read_done | input | 1 | Full data word has been read |
| rdy_n | output | 1 | Ready line, active low |
| stat_rdy | output | 1 | Status ready bit, 1 when an unread word is waiting |
| stat_stdy | output | 1 | Status steady bit, 1 while output is not settled |
| data_reg | output | DW | Data register contents |
| cal_we | output | 1 | Calibration coefficient write strobe |
| cal_wdata | output | DW | Coefficient to write |

## Verification
An error in the ready state shows on rdy_n one clock after the strobe that caused it. For example, a ready left low after a read, or a warning that did not raise the line, is visible immediately. A corrupted first-read marker or fast-path marker does not show until the next read or next settled load, when stat_stdy takes the wrong value. A wrong saturation choice, or a holding register that drops or replays a word, appears in data_reg on the edge after the load. The bench therefore checks data_reg and both flags after every strobe.

// File: rtl/conv_ready_ctrl.sv
module conv_ready_ctrl #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_n,
  input  logic          result_valid,
  input  logic [DW-1:0] result_data,
  input  logic          result_fast,
  input  logic          result_over,
  input  logic          result_under,
  input  logic          ref_missing,
  input  logic          upd_warn,
  input  logic          cal_start,
  input  logic          cal_done,
  input  logic [DW-1:0] cal_data,
  input  logic          read_busy,
  input  logic          read_done,
  output logic          rdy_n,
  output logic          stat_rdy,
  output logic          stat_stdy,
  output logic [DW-1:0] data_reg,
  output logic          cal_we,
  output logic [DW-1:0] cal_wdata
);

  localparam logic [DW-1:0] SAT_HI = {DW{1'b1}};
  localparam logic [DW-1:0] SAT_LO = {DW{1'b0}};

  logic          ready_q, stdy_q, in_cal_q, fast_used_q, first_rd_q;
  logic          pend_q, pend_fast_q;
  logic [DW-1:0] pend_val_q, data_q, cal_wdata_q;
  logic          cal_we_q;

  wire [DW-1:0] sat_val  = (ref_missing || result_over) ? SAT_HI :
                           result_under ? SAT_LO : result_data;
  wire          accept    = result_valid && !in_cal_q;
  wire          direct_ld = accept && !read_busy;
  wire          pend_ld   = pend_q && !read_busy;
  wire          do_ld     = direct_ld || pend_ld;
  wire [DW-1:0] ld_val    = direct_ld ? sat_val : pend_val_q;
  wire          ld_fast   = direct_ld ? result_fast : pend_fast_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      stdy_q      <= 1'b1;
      in_cal_q    <= 1'b0;
      fast_used_q <= 1'b0;
      first_rd_q  <= 1'b1;
      pend_q      <= 1'b0;
      pend_fast_q <= 1'b0;
      pend_val_q  <= SAT_LO;
      data_q      <= SAT_LO;
      cal_we_q    <= 1'b0;
      cal_wdata_q <= SAT_LO;
    end else if (!sync_n) begin
      ready_q     <= 1'b0;
      stdy_q      <= 1'b1;
      in_cal_q    <= 1'b0;
      fast_used_q <= 1'b0;
      first_rd_q  <= 1'b1;
      pend_q      <= 1'b0;
      cal_we_q    <= 1'b0;
    end else begin
      cal_we_q <= 1'b0;
      if (accept && read_busy) begin
        pend_q      <= 1'b1;
        pend_val_q  <= sat_val;
        pend_fast_q <= result_fast;
      end else if (pend_ld) begin
        pend_q <= 1'b0;
      end

      if (cal_start) begin
        ready_q     <= 1'b0;
        stdy_q      <= 1'b1;
        in_cal_q    <= 1'b1;
        fast_used_q <= 1'b0;
        first_rd_q  <= 1'b1;
        pend_q      <= 1'b0;
      end else if (cal_done && in_cal_q) begin
        in_cal_q    <= 1'b0;
        ready_q     <= 1'b1;
        cal_we_q    <= !ref_missing;
        cal_wdata_q <= cal_data;
      end else if (do_ld) begin
        data_q  <= ld_val;
        ready_q <= 1'b1;
        if (ld_fast) begin
          stdy_q      <= 1'b1;
          fast_used_q <= 1'b1;
        end else if (fast_used_q) begin
          stdy_q <= 1'b0;
        end
      end else if (upd_warn) begin
        ready_q <= 1'b0;
      end else if (read_done) begin
        ready_q <= 1'b0;
        if (first_rd_q && !fast_used_q) stdy_q <= 1'b0;
        first_rd_q <= 1'b0;
      end
    end
  end

  assign rdy_n     = !ready_q;
  assign stat_rdy  = ready_q;
  assign stat_stdy = stdy_q;
  assign data_reg  = data_q;
  assign cal_we    = cal_we_q;
  assign cal_wdata = cal_wdata_q;

  assert_sync_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> (rdy_n && stat_stdy));

  assert_load_lowers_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n && result_valid && !read_busy && !in_cal_q && !cal_start) |=> !rdy_n);

  assert_read_raises_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n && read_done && !result_valid && !pend_q && !cal_done && !cal_start) |=> rdy_n);

  assert_cal_start_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n && cal_start) |=> (rdy_n && stat_stdy));

  assert_cal_write_needs_ref_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cal_we |-> $past(cal_done && !ref_missing));

  assert_busy_freezes_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    read_busy |=> $stable(data_reg));

endmodule

// File: tb/test_conv_ready_ctrl.sv
`timescale 1ns/1ps
module test_conv_ready_ctrl;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, sync_n = 1'b1;
  logic result_valid = 1'b0, result_fast = 1'b0, result_over = 1'b0, result_under = 1'b0;
  logic ref_missing = 1'b0, upd_warn = 1'b0, cal_start = 1'b0, cal_done = 1'b0;
  logic read_busy = 1'b0, read_done = 1'b0;
  logic [DW-1:0] result_data = '0, cal_data = '0;
  logic rdy_n, stat_rdy, stat_stdy, cal_we;
  logic [DW-1:0] data_reg, cal_wdata;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  conv_ready_ctrl #(.DW(DW)) i_conv_ready_ctrl (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .result_valid(result_valid),
    .result_data(result_data), .result_fast(result_fast), .result_over(result_over),
    .result_under(result_under), .ref_missing(ref_missing), .upd_warn(upd_warn),
    .cal_start(cal_start), .cal_done(cal_done), .cal_data(cal_data),
    .read_busy(read_busy), .read_done(read_done), .rdy_n(rdy_n), .stat_rdy(stat_rdy),
    .stat_stdy(stat_stdy), .data_reg(data_reg), .cal_we(cal_we), .cal_wdata(cal_wdata));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic conv(input logic [DW-1:0] v, input logic f, input logic o, input logic u, input logic r);
    result_data = v; result_fast = f; result_over = o; result_under = u; ref_missing = r;
    result_valid = 1'b1;
    @(negedge clk);
    result_valid = 1'b0; result_over = 1'b0; result_under = 1'b0; ref_missing = 1'b0; result_fast = 1'b0;
  endtask

  task automatic rd();
    read_done = 1'b1;
    @(negedge clk);
    read_done = 1'b0;
  endtask

  task automatic resync();
    sync_n = 1'b0;
    @(negedge clk);
    sync_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdy_n", rdy_n, 1);
    chk("R1 stdy", stat_stdy, 1);
    chk("R1 data", data_reg, 0);
    chk("R1 cal_we", cal_we, 0);

    // R2 R10 R9 R8 sweep: every code under each override mode
    for (int v = 0; v < 256; v++) begin
      for (int m = 0; m < 4; m++) begin
        automatic int exp = (m == 1 || m == 3) ? 255 : (m == 2) ? 0 : v;
        automatic bit first = (v == 0 && m == 0);
        conv(v[DW-1:0], 1'b0, m == 1, m == 2, m == 3);
        chk("R2 rdy_n after load", rdy_n, 0);
        chk("R2 stat_rdy after load", stat_rdy, 1);
        chk(m == 3 ? "R9 noref data" : "R10 saturate data", data_reg, exp);
        chk("R8 stdy before/after first read", stat_stdy, first ? 1 : 0);
        rd();
        chk("R3 rdy_n after read", rdy_n, 1);
        chk("R8 stdy after read", stat_stdy, 0);
      end
    end

    // R4 warning then update
    conv(8'h5A, 0, 0, 0, 0);
    upd_warn = 1'b1; @(negedge clk); upd_warn = 1'b0;
    chk("R4 rdy_n after warn", rdy_n, 1);
    chk("R4 data kept", data_reg, 8'h5A);
    conv(8'h3C, 0, 0, 0, 0);
    chk("R4 rdy_n relowered", rdy_n, 0);
    chk("R4 data new", data_reg, 8'h3C);

    // R12 load and read together
    rd();
    read_done = 1'b1;
    conv(8'h66, 0, 0, 0, 0);
    read_done = 1'b0;
    chk("R12 rdy_n", rdy_n, 0);
    chk("R12 data", data_reg, 8'h66);

    // R5 sync hold
    conv(8'h11, 0, 0, 0, 0);
    sync_n = 1'b0;
    @(negedge clk);
    conv(8'h77, 0, 0, 0, 0);
    chk("R5 rdy_n", rdy_n, 1);
    chk("R5 stdy", stat_stdy, 1);
    chk("R5 data kept", data_reg, 8'h11);
    sync_n = 1'b1;
    @(negedge clk);

    // R7 fast-step path
    conv(8'h20, 1, 0, 0, 0);
    chk("R7 stdy fast", stat_stdy, 1);
    rd();
    chk("R7 stdy read during fast", stat_stdy, 1);
    conv(8'h21, 1, 0, 0, 0);
    chk("R7 stdy fast 2", stat_stdy, 1);
    conv(8'h22, 0, 0, 0, 0);
    chk("R7 stdy settled", stat_stdy, 0);
    chk("R7 rdy_n settled", rdy_n, 0);
    rd();
    chk("R7 stdy after read", stat_stdy, 0);

    // R8 no fast path after resync
    resync();
    conv(8'h30, 0, 0, 0, 0);
    chk("R8 stdy held", stat_stdy, 1);
    conv(8'h31, 0, 0, 0, 0);
    chk("R8 stdy held 2", stat_stdy, 1);
    rd();
    chk("R8 stdy cleared", stat_stdy, 0);
    conv(8'h32, 0, 0, 0, 0);
    rd();
    chk("R8 stdy stays low", stat_stdy, 0);

    // R6 calibration
    cal_start = 1'b1; @(negedge clk); cal_start = 1'b0;
    chk("R6 rdy_n at start", rdy_n, 1);
    chk("R6 stdy at start", stat_stdy, 1);
    conv(8'h99, 0, 0, 0, 0);
    chk("R6 data ignored", data_reg, 8'h32);
    chk("R6 rdy_n during cal", rdy_n, 1);
    cal_data = 8'hC3; cal_done = 1'b1; @(negedge clk); cal_done = 1'b0;
    chk("R6 cal_we", cal_we, 1);
    chk("R6 cal_wdata", cal_wdata, 8'hC3);
    chk("R6 rdy_n at done", rdy_n, 0);
    @(negedge clk);
    chk("R6 cal_we one cycle", cal_we, 0);

    // R9 calibration without reference
    cal_start = 1'b1; @(negedge clk); cal_start = 1'b0;
    cal_data = 8'h5E; ref_missing = 1'b1; cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0; ref_missing = 1'b0;
    chk("R9 cal_we suppressed", cal_we, 0);
    chk("R9 rdy_n at done", rdy_n, 0);

    // R11 read in progress
    rd();
    read_busy = 1'b1;
    conv(8'h44, 0, 0, 0, 0);
    chk("R11 data held", data_reg, 8'h32);
    chk("R11 rdy_n held", rdy_n, 1);
    @(negedge clk);
    chk("R11 data still held", data_reg, 8'h32);
    read_busy = 1'b0;
    @(negedge clk);
    chk("R11 data transferred", data_reg, 8'h44);
    chk("R11 rdy_n after transfer", rdy_n, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule